// File: doc/BRIEF.md
# Banked Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from a set of sources, splits them into equal banks and keeps, for each bank, a sticky status word and a mask word. A host reaches the four registers through a plain register bus with an address, write data, a write strobe, a read strobe and a read-data return. A status bit is cleared by writing a one to it. A mask bit at one silences its source.

A single active-high level interrupt is raised whenever any bank holds a status bit whose mask bit is zero. It stays up until the host clears that bit or masks it. The default build has two banks of 24 sources. Source number n belongs to bank n/24, bit n mod 24. Bank b has its status word at offset 3b and its mask word at offset 3b+1. The offset 3b+2 and every offset beyond the last bank hold no register.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, the interrupt output is low and the read data is 0.
- R2: Bank b has its status word at offset 3b and its mask word at offset 3b+1, so the defaults are offsets 0 and 1 for bank 0 and offsets 3 and 4 for bank 1. Reading any other offset returns 0, and writing to one changes no register.
- R3: The event input bit n sets status bit n mod 24 of bank n/24. With the defaults, bits 0 to 23 go to bank 0 and bits 24 to 47 go to bank 1.
- R4: A status bit that an event pulse has set stays at 1 until a write-one clear removes it.
- R5: Writing a status word clears each bit where the write data holds a 1 and leaves each bit where it holds a 0.
- R6: When an event pulse and a write-one clear reach the same status bit on the same clock edge, the bit ends up at 1.
- R7: A mask bit of 1 keeps its source out of the interrupt, but the status bit still latches the event.
- R8: The interrupt output is high, from the cycle after the clock edge that updates the registers, exactly when some bank has a status bit at 1 whose mask bit is 0. This includes unmasking a bit that is already pending.
- R9: The read data takes the addressed register's value on the clock edge where the read strobe is high and holds it until the next read. A mask word reads back exactly as written. A status word reads back its current sticky value in bits 23 to 0.
- R10: Writing 0xFFFFFF to every mask word drops the interrupt, whatever the status words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 48 | One-cycle event pulses, one per source |
| addr_i | input | 6 | Register offset |
| wdata_i | input | 24 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 24 | Registered read data |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
Directed sequences check the rules one at a time:
- A pulse on a bank-1 source, which separates the two banks' bit mapping.
- A pending bit that is then unmasked, which separates latching from raising the interrupt.
- A zero write followed by a one write to status, which separates a clear from a plain write.
- A pulse and a clear in the same cycle, which shows that the event wins.
- Writes to the offsets that hold no register, which shows that such offsets are truly inert.

A random phase then mixes sparse event pulses with writes and reads to every mapped offset and to the holes. A behavioural model follows it on every clock, checking the interrupt level and the read data.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Address layout: each bank occupies a stride of three offsets
    localparam int unsigned BANK_STRIDE = 3;
    localparam int unsigned STAT_SLOT   = 0;
    localparam int unsigned MASK_SLOT   = 1;

    function automatic int unsigned stat_off(input int unsigned bank);
        return bank * BANK_STRIDE + STAT_SLOT;
    endfunction

    function automatic int unsigned mask_off(input int unsigned bank);
        return bank * BANK_STRIDE + MASK_SLOT;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] stat_hit_o,
    output logic [NUM_BANKS-1:0] mask_hit_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign stat_hit_o[b] = (addr_i == ADDR_W'(stat_off(b)));
        assign mask_hit_o[b] = (addr_i == ADDR_W'(mask_off(b)));
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int unsigned BANK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] evt_i,
    input  logic              wr_stat_i,
    input  logic              wr_mask_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] stat_o,
    output logic [BANK_W-1:0] mask_o,
    output logic              pend_o
);

    logic [BANK_W-1:0] clr_vec;

    // Clear only the bits written as one; a new event overrides the clear
    assign clr_vec = wr_stat_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            mask_o <= '1;
        end else begin
            stat_o <= (stat_o & ~clr_vec) | evt_i;
            if (wr_mask_i) begin
                mask_o <= wdata_i;
            end
        end
    end

    assign pend_o = |(stat_o & ~mask_o);

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_en_i,
    input  logic [NUM_BANKS-1:0]               stat_hit_i,
    input  logic [NUM_BANKS-1:0]               mask_hit_i,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]   stat_i,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]   mask_i,
    output logic [BANK_W-1:0]                  rdata_o
);

    logic [BANK_W-1:0] rd_word;

    // Hits are mutually exclusive, so an OR of gated words selects one register
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (stat_hit_i[b]) rd_word = rd_word | stat_i[b];
            if (mask_hit_i[b]) rd_word = rd_word | mask_i[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_word;
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 24,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]   evt_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [BANK_W-1:0]             wdata_i,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    output logic [BANK_W-1:0]             rdata_o,
    output logic                          irq_o
);

    logic [NUM_BANKS-1:0]             stat_hit;
    logic [NUM_BANKS-1:0]             mask_hit;
    logic [NUM_BANKS-1:0][BANK_W-1:0] stat_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] mask_q;
    logic [NUM_BANKS-1:0]             bank_pend;

    irqc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr_i     (addr_i),
        .stat_hit_o (stat_hit),
        .mask_hit_o (mask_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[b*BANK_W +: BANK_W]),
            .wr_stat_i (wr_en_i & stat_hit[b]),
            .wr_mask_i (wr_en_i & mask_hit[b]),
            .wdata_i   (wdata_i),
            .stat_o    (stat_q[b]),
            .mask_o    (mask_q[b]),
            .pend_o    (bank_pend[b])
        );
    end

    irqc_rdmux #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .stat_hit_i (stat_hit),
        .mask_hit_i (mask_hit),
        .stat_i     (stat_q),
        .mask_i     (mask_q),
        .rdata_o    (rdata_o)
    );

    assign irq_o = |bank_pend;

endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 24,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_BANKS*BANK_W-1:0]   evt_i,
    input logic [ADDR_W-1:0]             addr_i,
    input logic [BANK_W-1:0]             wdata_i,
    input logic                          wr_en_i,
    input logic                          rd_en_i,
    input logic [BANK_W-1:0]             rdata_o,
    input logic                          irq_o,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] stat_q,
    input logic [NUM_BANKS-1:0][BANK_W-1:0] mask_q
);

    logic mapped;
    logic all_masked;

    always_comb begin
        mapped     = 1'b0;
        all_masked = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == ADDR_W'(stat_off(b)) || addr_i == ADDR_W'(mask_off(b)))
                mapped = 1'b1;
            if (mask_q[b] != '1)
                all_masked = 1'b0;
        end
    end

    // R10: every mask word at all ones keeps the interrupt low
    p_silenced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        all_masked |-> !irq_o);

    // R2: reading an offset that holds no register returns zero
    p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !mapped) |=> (rdata_o == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R3 / R6: every pulsed bit is set after the edge, clear or not
        p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_i[b*BANK_W +: BANK_W]) |=>
            ((stat_q[b] & $past(evt_i[b*BANK_W +: BANK_W])) == $past(evt_i[b*BANK_W +: BANK_W])));

        // R4: with no status write, no status bit falls
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && addr_i == ADDR_W'(stat_off(b))) |=>
            ((stat_q[b] & $past(stat_q[b])) == $past(stat_q[b])));

        // R5: bits written as one and not re-pulsed are cleared
        p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == ADDR_W'(stat_off(b))) |=>
            ((stat_q[b] & $past(wdata_i & ~evt_i[b*BANK_W +: BANK_W])) == '0));

        // R9: mask takes the written word
        p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == ADDR_W'(mask_off(b))) |=> (mask_q[b] == $past(wdata_i)));

        // R9: a mask read returns the mask held at the read edge
        p_mask_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && addr_i == ADDR_W'(mask_off(b))) |=> (rdata_o == $past(mask_q[b])));

        // R8: an unmasked pending bit drives the interrupt
        p_pending_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (|(stat_q[b] & ~mask_q[b])) |-> irq_o);
    end

endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .stat_q  (stat_q),
    .mask_q  (mask_q)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;

    localparam int NB = 2;
    localparam int BW = 24;
    localparam int AW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*BW-1:0]  evt_i = '0;
    logic [AW-1:0]     addr_i = '0;
    logic [BW-1:0]     wdata_i = '0;
    logic              wr_en_i = 1'b0;
    logic              rd_en_i = 1'b0;
    logic [BW-1:0]     rdata_o;
    logic              irq_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_bank_ctrl u_irq_bank_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Behavioural reference model
    bit [BW-1:0] m_stat [NB];
    bit [BW-1:0] m_mask [NB];
    bit [BW-1:0] m_rd;

    function automatic bit model_irq();
        bit r = 0;
        for (int b = 0; b < NB; b++) r |= |(m_stat[b] & ~m_mask[b]);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_stat[b] = '0;
                m_mask[b] = '1;
            end
            m_rd = '0;
        end else begin
            if (rd_en_i) begin
                m_rd = '0;
                for (int b = 0; b < NB; b++) begin
                    if (int'(addr_i) == 3*b)     m_rd = m_stat[b];
                    if (int'(addr_i) == 3*b + 1) m_rd = m_mask[b];
                end
            end
            for (int b = 0; b < NB; b++) begin
                if (wr_en_i && int'(addr_i) == 3*b) m_stat[b] &= ~wdata_i;
                m_stat[b] |= evt_i[b*BW +: BW];
                if (wr_en_i && int'(addr_i) == 3*b + 1) m_mask[b] = wdata_i;
            end
        end
    end

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%06h expected 0x%06h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 irq level", {23'b0, irq_o}, {23'b0, model_irq()});
            chk("R9 read data", rdata_o, m_rd);
        end
    end

    task automatic wr(input int a, input logic [BW-1:0] d);
        addr_i = AW'(a); wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, output logic [BW-1:0] d);
        addr_i = AW'(a); rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic pulse(input int n);
        evt_i = '0; evt_i[n] = 1'b1;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        logic [BW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {23'b0, irq_o}, '0);
        chk("R1 rdata after reset", rdata_o, '0);
        rd(1, v); chk("R1 mask0 reset", v, 24'hFFFFFF);
        rd(4, v); chk("R1 mask1 reset", v, 24'hFFFFFF);
        rd(3, v); chk("R1 status1 reset", v, '0);

        // R3 / R7 source 30 lands in bank 1 bit 6, masked
        pulse(30);
        rd(3, v); chk("R3 bank1 bit6", v, 24'h000040);
        rd(0, v); chk("R3 bank0 untouched", v, '0);
        chk("R7 masked no irq", {23'b0, irq_o}, '0);

        // R4 stays set over idle cycles
        repeat (5) @(negedge clk);
        rd(3, v); chk("R4 sticky", v, 24'h000040);

        // R8 unmask pending bit
        wr(4, 24'hFFFFBF);
        chk("R8 unmask raises irq", {23'b0, irq_o}, 24'h1);
        rd(4, v); chk("R9 mask readback", v, 24'hFFFFBF);

        // R5 zero write keeps, one write clears
        wr(3, 24'h000000);
        rd(3, v); chk("R5 zero write keeps", v, 24'h000040);
        wr(3, 24'h000040);
        rd(3, v); chk("R5 one write clears", v, '0);
        chk("R5 irq drops", {23'b0, irq_o}, '0);

        // R6 event and clear on the same edge
        pulse(30);
        addr_i = 6'd3; wdata_i = 24'h000040; wr_en_i = 1'b1; evt_i[30] = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0;
        rd(3, v); chk("R6 event wins", v, 24'h000040);

        // R2 holes inert
        wr(2, 24'hFFFFFF);
        wr(5, 24'hFFFFFF);
        rd(2, v); chk("R2 hole 2 reads zero", v, '0);
        rd(63, v); chk("R2 hole 63 reads zero", v, '0);
        rd(4, v); chk("R2 mask1 unchanged", v, 24'hFFFFBF);
        rd(3, v); chk("R2 status1 unchanged", v, 24'h000040);

        // R10 full masks silence pending sources
        pulse(0); pulse(23);
        wr(1, 24'h000000);
        chk("R8 bank0 irq", {23'b0, irq_o}, 24'h1);
        wr(1, 24'hFFFFFF);
        wr(4, 24'hFFFFFF);
        chk("R10 silenced", {23'b0, irq_o}, '0);
        rd(0, v); chk("R7 status kept while masked", v, 24'h800001);

        // Random phase, model compared each cycle
        for (int i = 0; i < 600; i++) begin
            int sel;
            evt_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                    & {$urandom, $urandom};
            sel = int'($urandom % 7);
            addr_i  = (sel == 6) ? 6'd63 : AW'(sel);
            wdata_i = BW'($urandom);
            wr_en_i = ($urandom % 3) == 0;
            rd_en_i = ($urandom % 2) == 0;
            @(negedge clk);
        end
        evt_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule